// File: doc/BRIEF.md
# Scanline Sync and Blank Generator

This block produces the horizontal timing of a retro console video chip. A free-running position counter on the pixel clock walks across a 228-clock scanline. Two windows are derived from the position: a 16-clock horizontal sync pulse and a 68-clock horizontal blank interval. The blank interval wraps through the end of the line, so the line carries 160 clocks of visible picture.

Software sets two control levels by writing to two registers: one selects vertical sync and the other vertical blank. Each level is taken from bit 1 of the written byte. The block merges these levels with the horizontal windows into two active-low composite pins. The sync pin inverts its polarity while vertical sync is held, which gives the serrated vertical pulse a television expects. A static option moves the blank window four clocks later, for displays that need that alignment. The raw position and an active-video flag are also brought out for the pixel logic.

Top module: `scan_sync_gen`

## Requirements
- R1: `hpos` counts 0, 1, ..., 227 and then returns to 0, advancing once per clock, so one scanline lasts 228 clocks.
- R2: The horizontal sync window covers positions 16 through 31 (16 clocks). It opens when the counter reaches 16 and closes when it reaches 32.
- R3: With `hblank_late` = 0, the horizontal blank window opens when the counter reaches 224 and closes when it reaches 64. This gives 68 blanked and 160 visible clocks per line. After reset the window stays closed until the counter first reaches 224.
- R4: With `hblank_late` = 1, the blank window opens when the counter reaches 0 (224 + 4, wrapped) and closes when it reaches 68. The sync window is unchanged.
- R5: `sync_n` equals (sync window) XNOR (vertical sync level). With vertical sync clear, it is low inside the sync window and high elsewhere. With vertical sync set, it is high inside the window and low elsewhere.
- R6: `blank_n` equals NOT(blank window OR vertical blank level).
- R7: A write happens on a clock edge where `wr_en` = 1. `wr_sel` = 0 loads the vertical sync level and `wr_sel` = 1 loads the vertical blank level, each from `wr_data[1]`. All other data bits are ignored, and the level that is not selected keeps its value.
- R8: Both pins are registered. The value on a pin is computed from the windows and control levels that held one clock earlier, so a pin shows the window of position `hpos`−1, and a control write shows on the pins one clock after the write edge.
- R9: `active_video` is high exactly when the blank window is closed for the position on `hpos`, whatever the vertical blank level.
- R10: Synchronous reset sets `hpos` to 0, clears both control levels, and closes both windows. While reset is held, `sync_n`, `blank_n` and `active_video` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 1 | 0 = vertical sync level, 1 = vertical blank level |
| wr_data | input | 8 | Write data; bit 1 is the level |
| hblank_late | input | 1 | Static option: blank window four clocks later |
| sync_n | output | 1 | Composite sync pin, active low |
| blank_n | output | 1 | Composite blank pin, active low |
| hpos | output | 8 | Horizontal position, 0 to 227 |
| active_video | output | 1 | High while horizontal blank is closed |

## Verification
Whole scanlines are run with both control levels clear. This separates the sync edges at 16 and 32 and the blank edges at 224 and 64 from each other and from the line wrap. The same lines are then repeated with vertical sync set, which must invert the sync pin but leave the blank pin alone. They are repeated again with vertical blank set, which must hold the blank pin low without moving `active_video`. Writes with bit 1 clear and every other bit set show that only bit 1 is decoded and that each select reaches only its own level. A reset with the late option set moves the blank edges to 0 and 68, while the sync edges must stay at 16 and 32.

// File: rtl/scan_sync_pkg.sv
`timescale 1ns/1ps
package scan_sync_pkg;

  typedef enum logic {
    SEL_VSYNC  = 1'b0,
    SEL_VBLANK = 1'b1
  } vctrl_sel_e;

  // Position after adding an offset on a line of 'len' clocks.
  function automatic int unsigned line_wrap(input int unsigned pos,
                                            input int unsigned ofs,
                                            input int unsigned len);
    return (pos + ofs) % len;
  endfunction

  // Half-open window test on a line position: start <= pos < stop,
  // or wrapping when start > stop.
  function automatic logic in_window(input int unsigned pos,
                                     input int unsigned start,
                                     input int unsigned stop);
    if (start <= stop) return (pos >= start) && (pos < stop);
    else               return (pos >= start) || (pos < stop);
  endfunction

endpackage

// File: rtl/scan_hcount.sv
`timescale 1ns/1ps
module scan_hcount #(
  parameter int unsigned LINE_CLKS = 228,
  parameter int unsigned HW        = $clog2(LINE_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hpos,
  output logic [HW-1:0] hpos_next,
  output logic          line_end
);

  localparam logic [HW-1:0] LAST_POS = HW'(LINE_CLKS - 1);

  assign line_end  = (hpos == LAST_POS);
  assign hpos_next = line_end ? '0 : hpos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) hpos <= '0;
    else     hpos <= hpos_next;
  end

  // R1: the last position is followed by zero
  p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (hpos == LAST_POS) |=> (hpos == '0));

  // R1: the counter never leaves the line
  p_pos_range_r1: assert property (@(posedge clk) disable iff (rst)
    (hpos <= LAST_POS));

endmodule

// File: rtl/scan_window.sv
`timescale 1ns/1ps
module scan_window #(
  parameter int unsigned HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hpos,
  input  logic [HW-1:0] hpos_next,
  input  logic [HW-1:0] open_at,
  input  logic [HW-1:0] close_at,
  output logic          win
);

  logic opening;
  logic closing;

  assign opening = (hpos_next == open_at);
  assign closing = (hpos_next == close_at);

  always_ff @(posedge clk) begin
    if (rst)          win <= 1'b0;
    else if (opening) win <= 1'b1;
    else if (closing) win <= 1'b0;
  end

  // R2, R3, R4: the window opens only at its start position
  p_window_open_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(win) |-> (hpos == open_at));

  // R2, R3, R4: the window closes only at its stop position
  p_window_close_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(win) |-> (hpos == close_at));

endmodule

// File: rtl/scan_vctrl.sv
`timescale 1ns/1ps
module scan_vctrl
  import scan_sync_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned CTRL_BIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          vsync_lvl,
  output logic          vblank_lvl
);

  logic wr_vsync;
  logic wr_vblank;
  logic new_lvl;

  assign wr_vsync  = wr_en && (vctrl_sel_e'(wr_sel) == SEL_VSYNC);
  assign wr_vblank = wr_en && (vctrl_sel_e'(wr_sel) == SEL_VBLANK);
  assign new_lvl   = wr_data[CTRL_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      vsync_lvl  <= 1'b0;
      vblank_lvl <= 1'b0;
    end else begin
      if (wr_vsync)  vsync_lvl  <= new_lvl;
      if (wr_vblank) vblank_lvl <= new_lvl;
    end
  end

  // R7: a vertical sync write loads bit CTRL_BIT and leaves blank alone
  p_vsync_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |=> (vsync_lvl == $past(wr_data[CTRL_BIT]))
                           && $stable(vblank_lvl));

  // R7: a vertical blank write loads bit CTRL_BIT and leaves sync alone
  p_vblank_write_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> (vblank_lvl == $past(wr_data[CTRL_BIT]))
                          && $stable(vsync_lvl));

  // R7: without a write the levels hold
  p_levels_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(vsync_lvl) && $stable(vblank_lvl)));

endmodule

// File: rtl/scan_pins.sv
`timescale 1ns/1ps
module scan_pins (
  input  logic clk,
  input  logic rst,
  input  logic hsync_win,
  input  logic hblank_win,
  input  logic vsync_lvl,
  input  logic vblank_lvl,
  output logic sync_n,
  output logic blank_n
);

  logic sync_n_d;
  logic blank_n_d;

  assign sync_n_d  = hsync_win ~^ vsync_lvl;
  assign blank_n_d = ~(hblank_win | vblank_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_n  <= 1'b1;
      blank_n <= 1'b1;
    end else begin
      sync_n  <= sync_n_d;
      blank_n <= blank_n_d;
    end
  end

  // R6, R8: vertical blank held over a full cycle forces the pin low
  p_vblank_pin_r6: assert property (@(posedge clk) disable iff (rst)
    vblank_lvl |=> !blank_n);

endmodule

// File: rtl/scan_sync_gen.sv
`timescale 1ns/1ps
module scan_sync_gen
  import scan_sync_pkg::*;
#(
  parameter int unsigned LINE_CLKS    = 228,
  parameter int unsigned HSYNC_START  = 16,
  parameter int unsigned HSYNC_STOP   = 32,
  parameter int unsigned HBLANK_START = 224,
  parameter int unsigned HBLANK_STOP  = 64,
  parameter int unsigned HBLANK_SHIFT = 4,
  parameter int unsigned DW           = 8,
  parameter int unsigned CTRL_BIT     = 1,
  parameter int unsigned HW           = $clog2(LINE_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          hblank_late,
  output logic          sync_n,
  output logic          blank_n,
  output logic [HW-1:0] hpos,
  output logic          active_video
);

  localparam logic [HW-1:0] HS_OPEN   = HW'(line_wrap(HSYNC_START, 0, LINE_CLKS));
  localparam logic [HW-1:0] HS_CLOSE  = HW'(line_wrap(HSYNC_STOP, 0, LINE_CLKS));
  localparam logic [HW-1:0] HB_OPEN_E = HW'(line_wrap(HBLANK_START, 0, LINE_CLKS));
  localparam logic [HW-1:0] HB_SHUT_E = HW'(line_wrap(HBLANK_STOP, 0, LINE_CLKS));
  localparam logic [HW-1:0] HB_OPEN_L = HW'(line_wrap(HBLANK_START, HBLANK_SHIFT, LINE_CLKS));
  localparam logic [HW-1:0] HB_SHUT_L = HW'(line_wrap(HBLANK_STOP, HBLANK_SHIFT, LINE_CLKS));

  logic [HW-1:0] hpos_next;
  logic          line_end;
  logic [HW-1:0] hb_open;
  logic [HW-1:0] hb_close;
  logic          hsync_win;
  logic          hblank_win;
  logic          vsync_lvl;
  logic          vblank_lvl;

  assign hb_open  = hblank_late ? HB_OPEN_L : HB_OPEN_E;
  assign hb_close = hblank_late ? HB_SHUT_L : HB_SHUT_E;

  scan_hcount #(.LINE_CLKS(LINE_CLKS), .HW(HW)) u_hcount (
    .clk       (clk),
    .rst       (rst),
    .hpos      (hpos),
    .hpos_next (hpos_next),
    .line_end  (line_end)
  );

  scan_window #(.HW(HW)) u_hsync_win (
    .clk       (clk),
    .rst       (rst),
    .hpos      (hpos),
    .hpos_next (hpos_next),
    .open_at   (HS_OPEN),
    .close_at  (HS_CLOSE),
    .win       (hsync_win)
  );

  scan_window #(.HW(HW)) u_hblank_win (
    .clk       (clk),
    .rst       (rst),
    .hpos      (hpos),
    .hpos_next (hpos_next),
    .open_at   (hb_open),
    .close_at  (hb_close),
    .win       (hblank_win)
  );

  scan_vctrl #(.DW(DW), .CTRL_BIT(CTRL_BIT)) u_vctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .vsync_lvl  (vsync_lvl),
    .vblank_lvl (vblank_lvl)
  );

  scan_pins u_pins (
    .clk        (clk),
    .rst        (rst),
    .hsync_win  (hsync_win),
    .hblank_win (hblank_win),
    .vsync_lvl  (vsync_lvl),
    .vblank_lvl (vblank_lvl),
    .sync_n     (sync_n),
    .blank_n    (blank_n)
  );

  assign active_video = ~hblank_win;

  // R2, R5, R8: the sync pin follows the sync window of the previous position
  p_sync_pin_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sync_n == (in_window(int'($past(hpos)), HSYNC_START, HSYNC_STOP)
                         ~^ $past(vsync_lvl))));

  // R9: a visible position reaches the blank pin unless vertical blank was set
  p_active_pin_r9: assert property (@(posedge clk) disable iff (rst)
    active_video |=> (blank_n || $past(vblank_lvl)));

  // R3, R4: the blank window only opens at the end of a line or the wrap
  p_blank_only_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hblank_win) |-> (hpos == hb_open));

endmodule

// File: tb/scan_sync_gen_bench.sv
`timescale 1ns/1ps
module scan_sync_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       hblank_late = 1'b0;
  logic       sync_n;
  logic       blank_n;
  logic [7:0] hpos;
  logic       active_video;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 0;

  // independent model state
  int mh   = 0;
  bit mhs  = 0;
  bit mhb  = 0;
  bit mvs  = 0;
  bit mvb  = 0;
  bit msync  = 1;
  bit mblank = 1;

  always #4 clk = ~clk;

  scan_sync_gen u_scan_sync_gen (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .hblank_late  (hblank_late),
    .sync_n       (sync_n),
    .blank_n      (blank_n),
    .hpos         (hpos),
    .active_video (active_video)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_miss++;
      $display("FAIL %s: actual %0d expected %0d (model pos %0d)", tag, act, exp, mh);
    end
  endtask

  // Model of one clock edge, built from the requirements.
  task automatic model_edge();
    int nx;
    int b_open;
    int b_close;
    if (rst) begin
      mh = 0; mhs = 0; mhb = 0; mvs = 0; mvb = 0; msync = 1; mblank = 1;
      return;
    end
    msync  = !(mhs ^ mvs);
    mblank = !(mhb | mvb);
    nx = (mh == 227) ? 0 : mh + 1;
    if (nx == 16) mhs = 1; else if (nx == 32) mhs = 0;
    b_open  = hblank_late ? 0  : 224;
    b_close = hblank_late ? 68 : 64;
    if (nx == b_open) mhb = 1; else if (nx == b_close) mhb = 0;
    if (wr_en) begin
      if (wr_sel) mvb = wr_data[1];
      else        mvs = wr_data[1];
    end
    mh = nx;
  endtask

  task automatic tick(input string pin_tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R1 hpos", int'(hpos), mh);
    check("R9 active_video", int'(active_video), int'(!mhb));
    check({pin_tag, " sync_n"}, int'(sync_n), int'(msync));
    check({pin_tag, " blank_n"}, int'(blank_n), int'(mblank));
  endtask

  task automatic run_clocks(input int n, input string pin_tag);
    for (int i = 0; i < n; i++) tick(pin_tag);
  endtask

  task automatic write_reg(input bit sel, input logic [7:0] d, input string tag);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick(tag);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_reset(input bit late);
    rst = 1'b1;
    hblank_late = late;
    run_clocks(3, "R10");
    check("R10 hpos in reset", int'(hpos), 0);
    check("R10 sync_n in reset", int'(sync_n), 1);
    check("R10 blank_n in reset", int'(blank_n), 1);
    check("R10 active in reset", int'(active_video), 1);
    rst = 1'b0;
  endtask

  // R10, R1, R2, R3: plain lines, control levels clear
  task automatic t_plain_lines();
    do_reset(1'b0);
    run_clocks(228 * 2 + 10, "R2/R3");
  endtask

  // R5, R8: vertical sync inverts the sync pin one clock after the write
  task automatic t_vsync_lines();
    write_reg(1'b0, 8'h02, "R8");
    run_clocks(228 + 40, "R5");
    write_reg(1'b0, 8'h00, "R8");
    run_clocks(50, "R5");
  endtask

  // R6, R9: vertical blank holds the blank pin, active flag unchanged
  task automatic t_vblank_lines();
    write_reg(1'b1, 8'h02, "R8");
    run_clocks(228, "R6");
    write_reg(1'b1, 8'h00, "R8");
    run_clocks(100, "R6");
  endtask

  // R7: only bit 1 is decoded, the other level is untouched
  task automatic t_ignored_bits();
    write_reg(1'b0, 8'hFD, "R7");
    run_clocks(60, "R7");
    write_reg(1'b1, 8'h02, "R7");
    write_reg(1'b0, 8'h02, "R7");
    run_clocks(20, "R7");
    write_reg(1'b1, 8'hFD, "R7");
    run_clocks(60, "R7");
    check("R7 sync level kept", int'(mvs), 1);
    write_reg(1'b0, 8'hFD, "R7");
    run_clocks(30, "R7");
  endtask

  // R4: late blank window at 0..67, sync untouched
  task automatic t_late_blank();
    do_reset(1'b1);
    run_clocks(228 * 2 + 20, "R4");
    write_reg(1'b1, 8'h02, "R4");
    run_clocks(30, "R4");
  endtask

  initial begin
    @(negedge clk);
    t_plain_lines();
    t_vsync_lines();
    t_vblank_lines();
    t_ignored_bits();
    t_late_blank();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_vec++;
      n_miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

endmodule